// File: doc/BRIEF.md
# ECC Error Address and Syndrome Logger

This block keeps a diagnostic record of ECC errors seen on memory read data. A read burst carries four quadwords (QW0 to QW3). Each quadword has its own correctable strobe, uncorrectable strobe and 8-bit syndrome. All four share one burst address made of rank, bank, row and column fields. When errors appear, the block selects one quadword by a fixed priority. It stores that quadword's syndrome and the burst address in a 64-bit log word and raises status flags. The stored fields then stay frozen until software clears the status.

A three-state controller governs the freeze:

- `ST_EMPTY`: nothing is logged.
- `ST_HOLD_COR`: a correctable error was logged.
- `ST_HOLD_UNC`: an uncorrectable error was logged, or followed a correctable one.

The transitions are:

- CAPTURE_COR: `ST_EMPTY` to `ST_HOLD_COR`, when only correctable errors arrive.
- CAPTURE_UNC: `ST_EMPTY` to `ST_HOLD_UNC`, when any uncorrectable error arrives.
- ESCALATE: `ST_HOLD_COR` to `ST_HOLD_UNC`, when an uncorrectable error arrives later. The fields are kept.
- RELEASE: a hold state to `ST_EMPTY`, on a clear with no error in the same cycle.
- RECAPTURE: a hold state to `ST_HOLD_COR` or `ST_HOLD_UNC`, on a clear in the same cycle as a new error, which is then logged.

The two status flags are also driven as level outputs for an error-message dispatcher. Every output is registered, so the effect of an input is visible one cycle after the edge that samples it.

Top module: `ecc_err_logger`

## Requirements
- R1: After reset the log word is all zeros and both status outputs are low.
- R2: Log word layout:
  - syndrome in bits [7:0]
  - column in [23:8]
  - row in [39:24]
  - bank in [42:40]
  - rank in [44:43]
  - zero in [61:45]
  - correctable flag in bit 62
  - uncorrectable flag in bit 63
- R3: When nothing is logged and an error strobe arrives, the log holds that burst's address and the chosen quadword's syndrome on the next cycle.
- R4: Within one burst, any uncorrectable quadword wins over any correctable one. Within each class the lowest quadword index wins. QW i's syndrome is taken from err_syn[8i+7:8i].
- R5: While either status flag is set and no clear is applied, new errors do not change the address or syndrome fields.
- R6: Any uncorrectable strobe sets the uncorrectable flag and any correctable strobe sets the correctable flag. Both flags stay set until a clear.
- R7: If a correctable error is logged and an uncorrectable error arrives later, the uncorrectable flag sets while the stored fields are kept.
- R8: A clear with no error strobe drops both flags on the next cycle and keeps the stored fields. The next error after that is captured.
- R9: A clear in the same cycle as an error logs the new error, and the flags show only that cycle's errors.
- R10: Status output sts_unc equals log bit 63 and sts_cor equals log bit 62 at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_unc | input | 4 | Uncorrectable error strobe per quadword (bit i = QW i) |
| err_cor | input | 4 | Correctable error strobe per quadword (bit i = QW i) |
| err_syn | input | 32 | Syndromes, QW i in bits [8i+7:8i] |
| addr_col | input | 16 | Column address of the burst |
| addr_row | input | 16 | Row address of the burst |
| addr_bank | input | 3 | Bank address of the burst |
| addr_rank | input | 2 | Rank address of the burst |
| sw_clr | input | 1 | Software clear of the status flags |
| log_word | output | 64 | Packed log word (layout in R2) |
| sts_unc | output | 1 | Uncorrectable flag level |
| sts_cor | output | 1 | Correctable flag level |

## Verification
The assertions check these properties on every cycle:

- The flags are sticky and are set by their strobes.
- A clear with no error empties the flags.
- The empty state never coexists with a set flag.
- The stored fields do not move unless a capture is issued.

Only the bench scenarios can show which quadword the priority selects when strobes mix across classes and indices. The same holds for the exact field values after escalation, release and a clear that coincides with a new error.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;

    localparam int QW_N_DEF   = 4;
    localparam int SYN_W_DEF  = 8;
    localparam int COL_W_DEF  = 16;
    localparam int ROW_W_DEF  = 16;
    localparam int BANK_W_DEF = 3;
    localparam int RANK_W_DEF = 2;
    localparam int LOG_W_DEF  = 64;

    typedef enum logic [1:0] {
        ST_EMPTY    = 2'd0,
        ST_HOLD_COR = 2'd1,
        ST_HOLD_UNC = 2'd2
    } lock_state_t;

endpackage

// File: rtl/ecc_qw_pick.sv
module ecc_qw_pick #(
    parameter int QW_N  = ecc_log_pkg::QW_N_DEF,
    parameter int SYN_W = ecc_log_pkg::SYN_W_DEF
) (
    input  logic [QW_N-1:0]       unc,
    input  logic [QW_N-1:0]       cor,
    input  logic [QW_N*SYN_W-1:0] syn_flat,
    output logic                  hit,
    output logic                  hit_unc,
    output logic [SYN_W-1:0]      syn_sel
);

    logic [QW_N-1:0]  cls_vec;
    logic [QW_N-1:0]  sel_oh;
    logic [SYN_W-1:0] masked [QW_N];

    // class selection: any uncorrectable strobe hides all correctable ones
    always_comb begin
        hit_unc = |unc;
        hit     = hit_unc | (|cor);
        cls_vec = hit_unc ? unc : cor;
    end

    // lowest index within the chosen class
    always_comb begin
        logic found;
        found  = 1'b0;
        sel_oh = '0;
        for (int i = 0; i < QW_N; i++) begin
            if (cls_vec[i] && !found) begin
                sel_oh[i] = 1'b1;
                found     = 1'b1;
            end
        end
    end

    genvar g;
    generate
        for (g = 0; g < QW_N; g++) begin : g_mask
            assign masked[g] = {SYN_W{sel_oh[g]}} & syn_flat[g*SYN_W +: SYN_W];
        end
    endgenerate

    always_comb begin
        syn_sel = '0;
        for (int i = 0; i < QW_N; i++) begin
            syn_sel = syn_sel | masked[i];
        end
    end

endmodule

// File: rtl/ecc_lock_fsm.sv
module ecc_lock_fsm
    import ecc_log_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic hit,
    input  logic any_unc,
    input  logic any_cor,
    output logic capture,
    output logic flag_unc,
    output logic flag_cor
);

    lock_state_t state_q, state_d;
    logic        unc_q, cor_q;
    logic        open_win;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            unc_q   <= 1'b0;
            cor_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            unc_q   <= (unc_q & ~clr) | any_unc;
            cor_q   <= (cor_q & ~clr) | any_cor;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (hit) state_d = any_unc ? ST_HOLD_UNC : ST_HOLD_COR;   // CAPTURE_UNC / CAPTURE_COR
            end
            ST_HOLD_COR: begin
                if (clr)          state_d = hit ? (any_unc ? ST_HOLD_UNC : ST_HOLD_COR) : ST_EMPTY; // RECAPTURE / RELEASE
                else if (any_unc) state_d = ST_HOLD_UNC;                                            // ESCALATE
            end
            ST_HOLD_UNC: begin
                if (clr) state_d = hit ? (any_unc ? ST_HOLD_UNC : ST_HOLD_COR) : ST_EMPTY;          // RECAPTURE / RELEASE
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        open_win = (state_q == ST_EMPTY) || clr;
        capture  = open_win && hit;
        flag_unc = unc_q;
        flag_cor = cor_q;
    end

    // R6
    unc_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_unc |=> flag_unc);
    // R6
    unc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_unc && !clr) |=> flag_unc);
    // R8
    clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !any_unc && !any_cor) |=> (!flag_unc && !flag_cor));
    // R5
    empty_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMPTY) |-> (!flag_unc && !flag_cor));

endmodule

// File: rtl/ecc_field_store.sv
module ecc_field_store #(
    parameter int SYN_W  = ecc_log_pkg::SYN_W_DEF,
    parameter int COL_W  = ecc_log_pkg::COL_W_DEF,
    parameter int ROW_W  = ecc_log_pkg::ROW_W_DEF,
    parameter int BANK_W = ecc_log_pkg::BANK_W_DEF,
    parameter int RANK_W = ecc_log_pkg::RANK_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SYN_W-1:0]  syn_in,
    input  logic [COL_W-1:0]  col_in,
    input  logic [ROW_W-1:0]  row_in,
    input  logic [BANK_W-1:0] bank_in,
    input  logic [RANK_W-1:0] rank_in,
    output logic [SYN_W-1:0]  syn_q,
    output logic [COL_W-1:0]  col_q,
    output logic [ROW_W-1:0]  row_q,
    output logic [BANK_W-1:0] bank_q,
    output logic [RANK_W-1:0] rank_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            syn_q  <= '0;
            col_q  <= '0;
            row_q  <= '0;
            bank_q <= '0;
            rank_q <= '0;
        end else if (load) begin
            syn_q  <= syn_in;
            col_q  <= col_in;
            row_q  <= row_in;
            bank_q <= bank_in;
            rank_q <= rank_in;
        end
    end

    // R5
    fields_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(syn_q) && $stable(col_q) && $stable(row_q)
                   && $stable(bank_q) && $stable(rank_q)));

endmodule

// File: rtl/ecc_err_logger.sv
module ecc_err_logger #(
    parameter int QW_N   = ecc_log_pkg::QW_N_DEF,
    parameter int SYN_W  = ecc_log_pkg::SYN_W_DEF,
    parameter int COL_W  = ecc_log_pkg::COL_W_DEF,
    parameter int ROW_W  = ecc_log_pkg::ROW_W_DEF,
    parameter int BANK_W = ecc_log_pkg::BANK_W_DEF,
    parameter int RANK_W = ecc_log_pkg::RANK_W_DEF,
    parameter int LOG_W  = ecc_log_pkg::LOG_W_DEF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [QW_N-1:0]       err_unc,
    input  logic [QW_N-1:0]       err_cor,
    input  logic [QW_N*SYN_W-1:0] err_syn,
    input  logic [COL_W-1:0]      addr_col,
    input  logic [ROW_W-1:0]      addr_row,
    input  logic [BANK_W-1:0]     addr_bank,
    input  logic [RANK_W-1:0]     addr_rank,
    input  logic                  sw_clr,
    output logic [LOG_W-1:0]      log_word,
    output logic                  sts_unc,
    output logic                  sts_cor
);

    localparam int USED_W = SYN_W + COL_W + ROW_W + BANK_W + RANK_W + 2;
    localparam int PAD_W  = LOG_W - USED_W;

    logic             hit, hit_unc, capture;
    logic [SYN_W-1:0] syn_pick;
    logic [SYN_W-1:0] syn_q;
    logic [COL_W-1:0] col_q;
    logic [ROW_W-1:0] row_q;
    logic [BANK_W-1:0] bank_q;
    logic [RANK_W-1:0] rank_q;
    logic             f_unc, f_cor;

    ecc_qw_pick #(.QW_N(QW_N), .SYN_W(SYN_W)) u_pick (
        .unc      (err_unc),
        .cor      (err_cor),
        .syn_flat (err_syn),
        .hit      (hit),
        .hit_unc  (hit_unc),
        .syn_sel  (syn_pick)
    );

    ecc_lock_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (sw_clr),
        .hit      (hit),
        .any_unc  (hit_unc),
        .any_cor  (|err_cor),
        .capture  (capture),
        .flag_unc (f_unc),
        .flag_cor (f_cor)
    );

    ecc_field_store #(
        .SYN_W(SYN_W), .COL_W(COL_W), .ROW_W(ROW_W),
        .BANK_W(BANK_W), .RANK_W(RANK_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (capture),
        .syn_in  (syn_pick),
        .col_in  (addr_col),
        .row_in  (addr_row),
        .bank_in (addr_bank),
        .rank_in (addr_rank),
        .syn_q   (syn_q),
        .col_q   (col_q),
        .row_q   (row_q),
        .bank_q  (bank_q),
        .rank_q  (rank_q)
    );

    assign log_word = {f_unc, f_cor, {PAD_W{1'b0}}, rank_q, bank_q, row_q, col_q, syn_q};
    assign sts_unc  = f_unc;
    assign sts_cor  = f_cor;

    // R7
    escalate_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_cor && !sts_unc && !sw_clr && (|err_unc))
        |=> (sts_unc && $stable(log_word[LOG_W-3:0])));

endmodule

// File: tb/ecc_err_logger_bench.sv
`timescale 1ns/1ps
module ecc_err_logger_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  err_unc = '0, err_cor = '0;
    logic [31:0] err_syn = '0;
    logic [15:0] addr_col = '0, addr_row = '0;
    logic [2:0]  addr_bank = '0;
    logic [1:0]  addr_rank = '0;
    logic        sw_clr = 1'b0;
    logic [63:0] log_word;
    logic        sts_unc, sts_cor;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ecc_err_logger u_ecc_err_logger (
        .clk(clk), .rst_n(rst_n), .err_unc(err_unc), .err_cor(err_cor),
        .err_syn(err_syn), .addr_col(addr_col), .addr_row(addr_row),
        .addr_bank(addr_bank), .addr_rank(addr_rank), .sw_clr(sw_clr),
        .log_word(log_word), .sts_unc(sts_unc), .sts_cor(sts_cor)
    );

    // reference model state, built from the requirements
    logic [15:0] m_col, m_row;
    logic [2:0]  m_bank;
    logic [1:0]  m_rank;
    logic [7:0]  m_syn;
    logic        m_unc, m_cor;

    typedef struct { logic [63:0] word; string tag; } exp_t;
    exp_t sq[$];

    function automatic logic [63:0] pack_log();
        return {m_unc, m_cor, 17'd0, m_rank, m_bank, m_row, m_col, m_syn};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: one burst per cycle, expected item pushed to the scoreboard
    task automatic burst(input logic [3:0] u, input logic [3:0] c, input logic [31:0] s,
                         input logic [15:0] col, input logic [15:0] row,
                         input logic [2:0] bk, input logic [1:0] rk, input bit clr,
                         input string tag);
        exp_t e;
        bit   locked;
        int   w;
        @(negedge clk);
        err_unc = u; err_cor = c; err_syn = s; addr_col = col; addr_row = row;
        addr_bank = bk; addr_rank = rk; sw_clr = clr;
        locked = (m_unc || m_cor) && !clr;
        if (clr) begin m_unc = 0; m_cor = 0; end
        if (!locked && (u != 0 || c != 0)) begin
            w = -1;
            for (int i = 3; i >= 0; i--) if (u[i]) w = i;
            if (w < 0) for (int i = 3; i >= 0; i--) if (c[i]) w = i;
            m_syn = s[w*8 +: 8];
            m_col = col; m_row = row; m_bank = bk; m_rank = rk;
        end
        if (u != 0) m_unc = 1;
        if (c != 0) m_cor = 1;
        e.word = pack_log();
        e.tag  = tag;
        sq.push_back(e);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sq.size() > 0) begin
                exp_t e;
                e = sq.pop_front();
                check(log_word === e.word, e.tag, log_word, e.word);
                // R10
                check(sts_unc === log_word[63] && sts_cor === log_word[62], "R10",
                      {62'd0, sts_unc, sts_cor}, {62'd0, log_word[63], log_word[62]});
            end
        end
    end

    initial begin
        m_col = 0; m_row = 0; m_bank = 0; m_rank = 0; m_syn = 0; m_unc = 0; m_cor = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1
        check(log_word === 64'd0 && !sts_unc && !sts_cor, "R1", log_word, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // R3 first correctable on QW2
        burst(4'b0000, 4'b0100, 32'h44332211, 16'h1234, 16'hABCD, 3'd5, 2'd2, 0, "R3");
        // R2 layout check
        @(posedge clk); #1;
        check(log_word[7:0] === 8'h33 && log_word[23:8] === 16'h1234 && log_word[39:24] === 16'hABCD
              && log_word[42:40] === 3'd5 && log_word[44:43] === 2'd2 && log_word[61:45] === 17'd0
              && log_word[62] === 1'b1, "R2", log_word, 64'h4000_15AB_CD12_3433);
        // R5 locked: later correctable ignored
        burst(4'b0000, 4'b0001, 32'hDEADBEEF, 16'h0F0F, 16'h7777, 3'd1, 2'd1, 0, "R5");
        // R7 escalation keeps fields
        burst(4'b0010, 4'b0000, 32'h0000AA00, 16'h5555, 16'h6666, 3'd2, 2'd3, 0, "R7");
        burst(4'b0000, 4'b0000, 32'h0, 16'h0, 16'h0, 3'd0, 2'd0, 0, "R6");
        // R8 clear alone
        burst(4'b0000, 4'b0000, 32'h0, 16'h9999, 16'h8888, 3'd7, 2'd0, 1, "R8");
        // R4 unc QW3 beats cor QW0
        burst(4'b1000, 4'b0001, 32'hC3B2A190, 16'h0101, 16'h0202, 3'd3, 2'd1, 0, "R4");
        burst(4'b0001, 4'b0000, 32'h000000FF, 16'h0303, 16'h0404, 3'd4, 2'd2, 0, "R5");
        // R9 clear with new correctables QW1 and QW3
        burst(4'b0000, 4'b1010, 32'h77665544, 16'hBEEF, 16'hCAFE, 3'd6, 2'd3, 1, "R9");
        burst(4'b0000, 4'b0000, 32'h0, 16'h0, 16'h0, 3'd0, 2'd0, 0, "R5");
        burst(4'b0000, 4'b0000, 32'h0, 16'h0, 16'h0, 3'd0, 2'd0, 1, "R8");
        // R4 unc on QW1 and QW2, cor on QW0
        burst(4'b0110, 4'b0001, 32'h13579BDF, 16'h2468, 16'h1357, 3'd0, 2'd0, 0, "R4");
        burst(4'b0000, 4'b0000, 32'h0, 16'h0, 16'h0, 3'd0, 2'd0, 1, "R8");
        // R4 correctables only, lowest index QW0
        burst(4'b0000, 4'b1001, 32'h01020304, 16'hFFFF, 16'h0001, 3'd7, 2'd3, 0, "R4");
        // R6 later unc after cor: both flags
        burst(4'b0100, 4'b0000, 32'h0, 16'h1, 16'h1, 3'd1, 2'd1, 0, "R6");
        burst(4'b0000, 4'b0000, 32'h0, 16'h0, 16'h0, 3'd0, 2'd0, 0, "R6");
        @(negedge clk);
        err_unc = '0; err_cor = '0; sw_clr = 0;
        repeat (3) @(posedge clk);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule